// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Leading-Bit Counting

This block is the integer execute stage of a load/store RISC datapath. Each cycle it takes two 64-bit operands, a 16-bit immediate, a 6-bit immediate shift amount and a 5-bit operation code. It computes one 64-bit result. When `use_imm_i` is set, the sign-extended immediate takes the place of the second operand. The result and a zero flag are captured in output registers, so a result appears one clock after its operands.

The operation set is made up of wrapping add and subtract, the four bitwise functions, and logical-left, logical-right and arithmetic-right shifts. Each shift takes its amount either from the instruction or from a register. The set also has signed and unsigned less-than compares, an upper-immediate load, and counts of leading zeros and leading ones. The unit has no multiply, divide, overflow trap or forwarding logic.

Top module: `xalu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the registers load `result_o = 0` and `zero_o = 1`. Otherwise, the result for the inputs present at a clock edge appears on `result_o` just after that edge.
- R2: Op 0 gives A + B and op 1 gives A − B, both modulo 2^64 with no overflow indication. B is `opb_i`, or `imm_i` sign-extended to 64 bits when `use_imm_i` = 1.
- R3: Op 2 gives A AND B, op 3 gives A OR B, op 4 gives A XOR B and op 5 gives NOT(A OR B).
- R4: Op 6 shifts A left logically, op 7 shifts A right logically and op 8 shifts A right arithmetically. For these three ops the amount is `shamt_i`.
- R5: Ops 9, 10 and 11 are the left-logical, right-logical and right-arithmetic shifts of A by bits 5:0 of B. The higher bits of B are ignored.
- R6: Op 12 gives 1 when A < B as signed numbers and 0 otherwise. Op 13 does the same compare as unsigned numbers.
- R7: Op 14 gives `imm_i` at bits 31:16 and zeros at bits 15:0. Bits 63:32 are copies of `imm_i[15]`.
- R8: Op 15 counts the leading zero bits of A and op 16 counts the leading one bits of A. Each count starts at bit 63 and gives 64 when A has no opposite bit.
- R9: `zero_o` is 1 exactly when `result_o` is 0.
- R10: Op codes 17 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B (register form) |
| imm_i | input | 16 | Immediate, sign-extended for B, placed in the upper half-word by op 14 |
| use_imm_i | input | 1 | Select the immediate as operand B |
| shamt_i | input | 6 | Shift amount for ops 6 to 8 |
| result_o | output | 64 | Registered result |
| zero_o | output | 1 | Registered result-is-zero flag |

## Verification
The state in this block is only the output register pair, so any fault shows up on `result_o` one clock after the offending operands. A result register and zero register that disagree are flagged in the same cycle. Faults in the shifter stages only show for amounts that use the broken stage. Faults in the count tree only show for the all-zero or all-one operands, or for values whose first opposite bit sits at a given position. The directed cases therefore cover every shift stage and both ends of the counts.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_AND  = 5'd2,
    OP_OR   = 5'd3,
    OP_XOR  = 5'd4,
    OP_NOR  = 5'd5,
    OP_SLL  = 5'd6,
    OP_SRL  = 5'd7,
    OP_SRA  = 5'd8,
    OP_SLLV = 5'd9,
    OP_SRLV = 5'd10,
    OP_SRAV = 5'd11,
    OP_SLT  = 5'd12,
    OP_SLTU = 5'd13,
    OP_LUI  = 5'd14,
    OP_CLZ  = 5'd15,
    OP_CLO  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/xalu_arith.sv
module xalu_arith #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W:0] diff_ext;

  assign sum_o    = a_i + b_i;
  // subtract as A + ~B + 1; the carry out is the inverted borrow
  assign diff_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
  assign diff_o   = diff_ext[W-1:0];
  assign lt_u_o   = ~diff_ext[W];
  assign lt_s_o   = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff_ext[W-1];
endmodule

// File: rtl/xalu_shift.sv
module xalu_shift
  import xalu_pkg::*;
#(
  parameter int W  = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din_i,
  input  logic [SW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  dout_o
);
  logic [W-1:0] din_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stage [0:SW];
  logic         left;
  logic         fill;

  assign left = (kind_i == SH_LEFT);
  assign fill = (kind_i == SH_RARI) & din_i[W-1];

  // a left shift is a right shift of the bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i] = din_i[W-1-i];
    assign out_rev[i] = stage[SW][W-1-i];
  end

  assign stage[0] = left ? din_rev : din_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{SH{fill}}, stage[k][W-1:SH]} : stage[k];
  end

  assign dout_o = left ? out_rev : stage[SW];
endmodule

// File: rtl/xalu_lcount.sv
module xalu_lcount #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  x_i,
  output logic [CW-1:0] lz_o
);
  // the highest set bit wins, so later iterations override earlier ones
  always_comb begin
    lz_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (x_i[i]) lz_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/xalu_top.sv
module xalu_top
  import xalu_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16,
  localparam int SW   = $clog2(W),
  localparam int CW   = SW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic [SW-1:0]    shamt_i,
  output logic [W-1:0]     result_o,
  output logic             zero_o
);
  logic [W-1:0]  b_eff;
  logic [W-1:0]  lui_val;
  logic [W-1:0]  sum, diff, sh_out, nxt;
  logic          lt_s, lt_u;
  logic [SW-1:0] sh_amt;
  shift_kind_e   sh_kind;
  logic [CW-1:0] cnt_z, cnt_o;

  assign b_eff   = use_imm_i ? {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : opb_i;
  assign lui_val = {{(W-2*IMM_W){imm_i[IMM_W-1]}}, imm_i, {IMM_W{1'b0}}};

  xalu_arith #(.W(W)) u_arith (
    .a_i(opa_i), .b_i(b_eff), .sum_o(sum), .diff_o(diff),
    .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  always_comb begin
    sh_kind = SH_LEFT;
    sh_amt  = shamt_i;
    case (op_i)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      OP_SLLV: sh_amt  = b_eff[SW-1:0];
      OP_SRLV: begin sh_kind = SH_RLOG; sh_amt = b_eff[SW-1:0]; end
      OP_SRAV: begin sh_kind = SH_RARI; sh_amt = b_eff[SW-1:0]; end
      default: ;
    endcase
  end

  xalu_shift #(.W(W)) u_shift (
    .din_i(opa_i), .amt_i(sh_amt), .kind_i(sh_kind), .dout_o(sh_out)
  );

  xalu_lcount #(.W(W)) u_clz (.x_i(opa_i),  .lz_o(cnt_z));
  xalu_lcount #(.W(W)) u_clo (.x_i(~opa_i), .lz_o(cnt_o));

  always_comb begin
    case (op_i)
      OP_ADD:  nxt = sum;
      OP_SUB:  nxt = diff;
      OP_AND:  nxt = opa_i & b_eff;
      OP_OR:   nxt = opa_i | b_eff;
      OP_XOR:  nxt = opa_i ^ b_eff;
      OP_NOR:  nxt = ~(opa_i | b_eff);
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV: nxt = sh_out;
      OP_SLT:  nxt = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: nxt = {{(W-1){1'b0}}, lt_u};
      OP_LUI:  nxt = lui_val;
      OP_CLZ:  nxt = {{(W-CW){1'b0}}, cnt_z};
      OP_CLO:  nxt = {{(W-CW){1'b0}}, cnt_o};
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= nxt;
      zero_o   <= (nxt == '0);
    end
  end
endmodule

// File: rtl/xalu_chk.sv
module xalu_chk
  import xalu_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       op_i,
  input logic [W-1:0]     opa_i,
  input logic [W-1:0]     opb_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic [W-1:0]     result_o,
  input logic             zero_o
);
  logic [W-1:0] b_chk;
  assign b_chk = use_imm_i ? {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : opb_i;

  assert_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (result_o == '0 && zero_o));

  assert_add_R2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (result_o == $past(opa_i + b_chk)));

  assert_nor_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOR) |=> ((result_o & $past(opa_i)) == '0));

  assert_compare_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLT || op_i == OP_SLTU) |=> (result_o[W-1:1] == '0));

  assert_upper_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LUI) |=> (result_o[IMM_W-1:0] == '0 &&
                          result_o[W-1] == result_o[2*IMM_W-1]));

  assert_count_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CLZ || op_i == OP_CLO) |=> (result_o <= W));

  assert_zero_R9: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  assert_undef_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i > 5'd16) |=> (result_o == '0));
endmodule

bind xalu_top xalu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
  .imm_i(imm_i), .use_imm_i(use_imm_i), .result_o(result_o), .zero_o(zero_o)
);

// File: tb/tb_xalu_top.sv
module tb_xalu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op;
  logic [63:0] opa, opb;
  logic [15:0] imm;
  logic        use_imm;
  logic [5:0]  shamt;
  logic [63:0] result;
  logic        zero;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xalu_top dut (
    .clk(clk), .rst(rst), .op_i(op), .opa_i(opa), .opb_i(opb),
    .imm_i(imm), .use_imm_i(use_imm), .shamt_i(shamt),
    .result_o(result), .zero_o(zero)
  );

  function automatic logic [63:0] lead(input logic [63:0] v, input logic bitval);
    logic [63:0] n = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i] != bitval) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] a,
      input logic [63:0] bi, input logic ui, input logic [15:0] im, input logic [5:0] sa);
    logic [63:0] b = ui ? {{48{im[15]}}, im} : bi;
    case (o)
      0:  return a + b;
      1:  return a - b;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return ~(a | b);
      6:  return a << sa;
      7:  return a >> sa;
      8:  return $unsigned($signed(a) >>> sa);
      9:  return a << b[5:0];
      10: return a >> b[5:0];
      11: return $unsigned($signed(a) >>> b[5:0]);
      12: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      13: return (a < b) ? 64'd1 : 64'd0;
      14: return {{32{im[15]}}, im, 16'h0};
      15: return lead(a, 1'b0);
      16: return lead(a, 1'b1);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag(input logic [4:0] o);
    if (o <= 1) return "R2";
    if (o <= 5) return "R3";
    if (o <= 8) return "R4";
    if (o <= 11) return "R5";
    if (o <= 13) return "R6";
    if (o == 14) return "R7";
    if (o <= 16) return "R8";
    return "R10";
  endfunction

  task automatic run(input logic [4:0] o, input logic [63:0] a, input logic [63:0] b,
      input logic ui, input logic [15:0] im, input logic [5:0] sa);
    logic [63:0] exp = model(o, a, b, ui, im, sa);
    op = o; opa = a; opb = b; use_imm = ui; imm = im; shamt = sa;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== exp || zero !== (exp == 64'd0)) begin
      fails++;
      $display("FAIL %s/R9 op=%0d result=%h zero=%b expected %h zero=%b",
               tag(o), o, result, zero, exp, exp == 64'd0);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; op = 5'd0; opa = 64'h55; opb = 64'h1; imm = 0; use_imm = 0; shamt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1 reset state
    if (result !== 64'd0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R1 result=%h zero=%b expected 0 zero=1", result, zero);
    end
    rst = 1'b0;
    // R2 wrap and immediate operand
    run(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    run(1, 64'd0, 64'd1, 0, 0, 0);
    run(0, 64'd10, 64'd0, 1, 16'hFFFF, 0);
    run(1, 64'd5, 64'd99, 1, 16'h0005, 0);
    // R3 logic
    run(5, 64'hF0F0_0000_0000_0001, 64'h0F0F_0000_0000_0000, 0, 0, 0);
    run(2, 64'hFFFF_FFFF_0000_FFFF, 64'd0, 1, 16'h8001, 0);
    run(4, 64'hA5A5_A5A5_A5A5_A5A5, 64'hA5A5_A5A5_A5A5_A5A5, 0, 0, 0);
    // R4 immediate shifts at each stage and the extremes
    for (int s = 0; s < 6; s++) begin
      run(6, 64'h8000_0000_0000_0001, 0, 0, 0, 6'(1 << s));
      run(7, 64'h8000_0000_0000_0001, 0, 0, 0, 6'(1 << s));
      run(8, 64'h8000_0000_0000_0001, 0, 0, 0, 6'(1 << s));
    end
    run(8, 64'h8000_0000_0000_0000, 0, 0, 0, 6'd63);
    run(7, 64'h8000_0000_0000_0000, 0, 0, 0, 6'd63);
    // R5 variable shifts ignore the upper bits of B
    run(9,  64'd1, 64'hFFFF_FFFF_FFFF_FFC1, 0, 0, 6'd7);
    run(10, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0142, 0, 0, 6'd0);
    run(11, 64'h8000_0000_0000_0000, 64'd0, 1, 16'h7FFF, 6'd0);
    // R6 signed against unsigned
    run(12, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    run(13, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    run(12, 64'd3, 64'd3, 0, 0, 0);
    run(13, 64'd2, 64'd0, 1, 16'hFFFF, 0);
    // R7 upper immediate, both signs
    run(14, 64'hDEAD, 64'hBEEF, 0, 16'h8001, 0);
    run(14, 64'd0, 64'd0, 1, 16'h1234, 0);
    // R8 counts with no opposite bit and with one at each end
    run(15, 64'd0, 0, 0, 0, 0);
    run(16, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    run(15, 64'h8000_0000_0000_0000, 0, 0, 0, 0);
    run(15, 64'd1, 0, 0, 0, 0);
    run(16, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 0);
    run(16, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    // R10 undefined codes
    run(17, 64'h1234, 64'h1, 0, 0, 0);
    run(31, 64'hFFFF, 64'hFFFF, 0, 0, 0);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) a = a >> $urandom_range(0, 63);
      if ($urandom_range(0, 7) == 0) a = ~(a >> $urandom_range(0, 63));
      if ($urandom_range(0, 9) == 0) b = a;
      run(5'($urandom_range(0, 19)), a, b, 1'($urandom), 16'($urandom), 6'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule